// File: doc/BRIEF.md
# Packet-Filter VM ALU Unit

This block executes the arithmetic, logical, shift, move and byte-order instructions of a 64-bit packet-filter virtual machine. Each cycle it can take one decoded 8-bit opcode together with the current destination register value, the source register value and the 32-bit immediate. One clock later it presents the 64-bit value to write back to the destination register, plus a write-enable that says whether the opcode was one it executes.

The low three opcode bits give the instruction class. The class picks full 64-bit operation or 32-bit operation. The next bit chooses between the immediate and the source register. The upper nibble names the operation. Register-file storage, instruction fetch, memory access and branching are handled elsewhere. The unit only computes a result, and the surrounding pipeline performs the write.

Top module: `pfvm_alu`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. Whenever `out_valid` is low, `out_wr_en` is low. A synchronous active-low reset clears `out_valid`, `out_wr_en` and `out_result` to zero.
- R2: Opcode bits [2:0] select the class: 3'h7 is the 64-bit class and 3'h4 is the 32-bit class. Bit 3 selects the second operand: 0 takes the immediate and 1 takes the source register. Bits [7:4] select the operation: add 0, sub 1, mul 2, div 3, or 4, and 5, lsh 6, rsh 7, neg 8, mod 9, xor A, mov B, arsh C, byte-order D.
- R3: Add, sub and mul return the low 64 bits of the result. In the 64-bit class, the immediate is sign-extended to 64 bits before use.
- R4: Div is unsigned. A zero divisor gives a result of 0 with write-enable high.
- R5: Mod is an unsigned remainder. A zero divisor returns the full 64-bit destination value unchanged, in both classes.
- R6: Or, and and xor combine the two operands bitwise. Mov returns the second operand.
- R7: The shift amount is taken from the low 6 bits of the second operand in the 64-bit class and from the low 5 bits in the 32-bit class. Lsh and rsh fill vacated bits with zeros. Arsh fills vacated bits with copies of the operating-width sign bit.
- R8: Neg returns the two's-complement negation of the destination at the operating width.
- R9: The byte-order operation (D) uses the immediate as the width: 16, 32 or 64 bits. With bit 3 = 0 (little-endian, matching the host), the result is the low width bits of the destination, zero-extended. With bit 3 = 1 (big-endian), the bytes within that width are reversed and the result is zero-extended. Both classes behave the same for this operation.
- R10: The unit reports `out_wr_en` = 0 and `out_result` = 0 in three cases: a class other than 3'h4 or 3'h7, operation codes E and F, and a byte-order width other than 16, 32 or 64.
- R11: In the 32-bit class, operands are the low 32 bits of the inputs and the upper 32 result bits are zero. The exceptions are mod by zero and the byte-order operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | An instruction is present this cycle |
| opcode | input | 8 | Decoded opcode: operation, source select, class |
| dst_val | input | 64 | Current destination register value |
| src_val | input | 64 | Source register value |
| imm | input | 32 | Instruction immediate |
| out_valid | output | 1 | Result of the previous cycle's instruction is present |
| out_wr_en | output | 1 | Result should be written to the destination |
| out_result | output | 64 | Write-back value |

## Verification
The hardest cases to reach from the ports are the operand-dependent corners. These are divisors of exactly zero, shift amounts at or just past the mask boundary (such as 63, 64 and 33 in the 32-bit class), negation of zero and of the most negative value, and immediates with bit 31 set that must sign-extend in one class but not the other. The directed part of the stimulus places these values on the operand ports explicitly and sends each through both classes and both source selections. A long mixed sequence then follows. It includes idle gaps, back-to-back issue, illegal classes and operation codes, and byte-order widths drawn both from the legal set and at random.

// File: rtl/pfvm_pkg.sv
// Shared constants and types for the packet-filter VM ALU unit.
// Assumes a 64-bit register width and a 32-bit immediate.
package pfvm_pkg;
    localparam int XLEN  = 64;
    localparam int IMM_W = 32;
    localparam int OPC_W = 8;

    localparam logic [2:0] CLS_ALU32 = 3'h4;
    localparam logic [2:0] CLS_ALU64 = 3'h7;

    typedef enum logic [3:0] {
        OP_ADD  = 4'h0,
        OP_SUB  = 4'h1,
        OP_MUL  = 4'h2,
        OP_DIV  = 4'h3,
        OP_OR   = 4'h4,
        OP_AND  = 4'h5,
        OP_LSH  = 4'h6,
        OP_RSH  = 4'h7,
        OP_NEG  = 4'h8,
        OP_MOD  = 4'h9,
        OP_XOR  = 4'hA,
        OP_MOV  = 4'hB,
        OP_ARSH = 4'hC,
        OP_END  = 4'hD
    } alu_op_e;

    typedef enum logic [1:0] {
        SW_QUARTER = 2'd0,
        SW_HALF    = 2'd1,
        SW_FULL    = 2'd2,
        SW_BAD     = 2'd3
    } swap_w_e;
endpackage

// File: rtl/pfvm_decode.sv
// Opcode decoder and operand selector.
// Splits the opcode into class, source select and operation.
// Builds the two operands at the operating width and extracts the masked shift amount.
// Assumes W is a power of two and IW <= W.
module pfvm_decode
    import pfvm_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int IW = IMM_W
) (
    input  logic [OPC_W-1:0]     opcode,
    input  logic [W-1:0]         dst_val,
    input  logic [W-1:0]         src_val,
    input  logic [IW-1:0]        imm,
    output alu_op_e              op,
    output logic                 class_ok,
    output logic                 wide,
    output logic                 src_reg,
    output logic [W-1:0]         opa,
    output logic [W-1:0]         opb,
    output logic [$clog2(W)-1:0] shamt,
    output swap_w_e              swap_w
);
    localparam int H   = W / 2;
    localparam int SHW = $clog2(W);

    logic [W-1:0] imm_ext;
    logic [W-1:0] raw_b;

    // Field split of the opcode byte.
    always_comb begin
        op       = alu_op_e'(opcode[7:4]);
        src_reg  = opcode[3];
        wide     = (opcode[2:0] == CLS_ALU64);
        class_ok = wide || (opcode[2:0] == CLS_ALU32);
    end

    // Second operand before width narrowing.
    always_comb begin
        imm_ext = {{(W-IW){imm[IW-1]}}, imm};
        raw_b   = src_reg ? src_val : imm_ext;
    end

    // Operands narrowed to the low half in the 32-bit class.
    always_comb begin
        opa = wide ? dst_val : {{H{1'b0}}, dst_val[H-1:0]};
        opb = wide ? raw_b   : {{H{1'b0}}, raw_b[H-1:0]};
    end

    // Shift amount masked to the operating width.
    always_comb begin
        shamt = wide ? raw_b[SHW-1:0] : {1'b0, raw_b[SHW-2:0]};
    end

    // Byte-order width taken from the immediate.
    always_comb begin
        if (imm == IW'(W / 4))      swap_w = SW_QUARTER;
        else if (imm == IW'(W / 2)) swap_w = SW_HALF;
        else if (imm == IW'(W))     swap_w = SW_FULL;
        else                        swap_w = SW_BAD;
    end
endmodule

// File: rtl/pfvm_arith.sv
// Arithmetic datapath: add, sub, mul, unsigned div and unsigned mod.
// Assumes operands arrive already narrowed by the decoder.
// A zero divisor gives 0 for div and the untouched destination for mod.
module pfvm_arith
    import pfvm_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_op_e      op,
    input  logic         wide,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic [W-1:0] dst_val,
    output logic [W-1:0] res
);
    localparam int H = W / 2;

    logic         div_zero;
    logic [W-1:0] sum, diff, prod, quot, rem;
    logic [W-1:0] pick;

    // Candidate results of every arithmetic operation.
    always_comb begin
        div_zero = (opb == '0);
        sum      = opa + opb;
        diff     = opa - opb;
        prod     = opa * opb;
        quot     = div_zero ? '0 : opa / opb;
        rem      = div_zero ? '0 : opa % opb;
    end

    // Operation select.
    always_comb begin
        case (op)
            OP_ADD:  pick = sum;
            OP_SUB:  pick = diff;
            OP_MUL:  pick = prod;
            OP_DIV:  pick = quot;
            OP_MOD:  pick = rem;
            default: pick = '0;
        endcase
    end

    // Width fix-up, with the mod-by-zero bypass.
    always_comb begin
        if (op == OP_MOD && div_zero) res = dst_val;
        else if (wide)                res = pick;
        else                          res = {{H{1'b0}}, pick[H-1:0]};
    end
endmodule

// File: rtl/pfvm_logic_shift.sv
// Bitwise, move, negate and shift datapath.
// Assumes operands are already narrowed and the shift amount is already masked.
// Arithmetic right shift uses the sign bit of the operating width.
module pfvm_logic_shift
    import pfvm_pkg::*;
#(
    parameter int W = XLEN
) (
    input  alu_op_e              op,
    input  logic                 wide,
    input  logic [W-1:0]         opa,
    input  logic [W-1:0]         opb,
    input  logic [$clog2(W)-1:0] shamt,
    output logic [W-1:0]         res
);
    localparam int H = W / 2;

    logic [W-1:0] lsh_v, rsh_v, neg_v, arsh_w;
    logic [H-1:0] arsh_n;
    logic [W-1:0] pick;

    // Shift and negate candidates.
    always_comb begin
        lsh_v  = opa << shamt;
        rsh_v  = opa >> shamt;
        neg_v  = '0 - opa;
        arsh_w = $signed(opa) >>> shamt;
        arsh_n = $signed(opa[H-1:0]) >>> shamt;
    end

    // Operation select.
    always_comb begin
        case (op)
            OP_OR:   pick = opa | opb;
            OP_AND:  pick = opa & opb;
            OP_XOR:  pick = opa ^ opb;
            OP_MOV:  pick = opb;
            OP_LSH:  pick = lsh_v;
            OP_RSH:  pick = rsh_v;
            OP_NEG:  pick = neg_v;
            OP_ARSH: pick = wide ? arsh_w : {{H{1'b0}}, arsh_n};
            default: pick = '0;
        endcase
    end

    // Zero the upper half in the 32-bit class.
    always_comb begin
        res = wide ? pick : {{H{1'b0}}, pick[H-1:0]};
    end
endmodule

// File: rtl/pfvm_byteswap.sv
// Byte-order converter for quarter, half and full register widths.
// The host is little-endian: little-endian conversion truncates and zero-extends.
// Big-endian conversion reverses the bytes inside the width and zero-extends.
// Assumes W is a multiple of 32.
module pfvm_byteswap
    import pfvm_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] din,
    input  logic         big,
    input  swap_w_e      sel,
    output logic [W-1:0] dout
);
    localparam int NB = W / 8;
    localparam int HW = W / 2;
    localparam int QW = W / 4;

    logic [W-1:0]  rev_f;
    logic [HW-1:0] rev_h;
    logic [QW-1:0] rev_q;

    genvar g;
    generate
        for (g = 0; g < NB; g++) begin : g_full
            assign rev_f[8*g +: 8] = din[8*(NB-1-g) +: 8];
        end
        for (g = 0; g < NB/2; g++) begin : g_half
            assign rev_h[8*g +: 8] = din[8*(NB/2-1-g) +: 8];
        end
        for (g = 0; g < NB/4; g++) begin : g_quarter
            assign rev_q[8*g +: 8] = din[8*(NB/4-1-g) +: 8];
        end
    endgenerate

    // Width and endianness select.
    always_comb begin
        case (sel)
            SW_QUARTER: dout = big ? {{(W-QW){1'b0}}, rev_q} : {{(W-QW){1'b0}}, din[QW-1:0]};
            SW_HALF:    dout = big ? {{(W-HW){1'b0}}, rev_h} : {{(W-HW){1'b0}}, din[HW-1:0]};
            SW_FULL:    dout = big ? rev_f : din;
            default:    dout = '0;
        endcase
    end
endmodule

// File: rtl/pfvm_alu.sv
// Packet-filter VM ALU unit top.
// Decodes the opcode, runs the arithmetic, logic/shift and byte-order datapaths,
// and registers the selected result with a one-cycle valid.
// Assumes the caller holds its inputs for the cycle in which in_valid is high.
module pfvm_alu
    import pfvm_pkg::*;
#(
    parameter int W  = XLEN,
    parameter int IW = IMM_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [OPC_W-1:0] opcode,
    input  logic [W-1:0]     dst_val,
    input  logic [W-1:0]     src_val,
    input  logic [IW-1:0]    imm,
    output logic             out_valid,
    output logic             out_wr_en,
    output logic [W-1:0]     out_result
);
    localparam int H   = W / 2;
    localparam int SHW = $clog2(W);

    alu_op_e        dec_op;
    logic           dec_class_ok, dec_wide, dec_src_reg;
    logic [W-1:0]   dec_opa, dec_opb;
    logic [SHW-1:0] dec_shamt;
    swap_w_e        dec_swap;
    logic [W-1:0]   arith_res, ls_res, bs_res;
    logic [W-1:0]   nxt_res;
    logic           nxt_wr;

    pfvm_decode #(.W(W), .IW(IW)) u_dec (
        .opcode   (opcode),
        .dst_val  (dst_val),
        .src_val  (src_val),
        .imm      (imm),
        .op       (dec_op),
        .class_ok (dec_class_ok),
        .wide     (dec_wide),
        .src_reg  (dec_src_reg),
        .opa      (dec_opa),
        .opb      (dec_opb),
        .shamt    (dec_shamt),
        .swap_w   (dec_swap)
    );

    pfvm_arith #(.W(W)) u_arith (
        .op      (dec_op),
        .wide    (dec_wide),
        .opa     (dec_opa),
        .opb     (dec_opb),
        .dst_val (dst_val),
        .res     (arith_res)
    );

    pfvm_logic_shift #(.W(W)) u_ls (
        .op    (dec_op),
        .wide  (dec_wide),
        .opa   (dec_opa),
        .opb   (dec_opb),
        .shamt (dec_shamt),
        .res   (ls_res)
    );

    pfvm_byteswap #(.W(W)) u_bs (
        .din  (dst_val),
        .big  (dec_src_reg),
        .sel  (dec_swap),
        .dout (bs_res)
    );

    // Result steering and legality check.
    always_comb begin
        nxt_res = '0;
        nxt_wr  = 1'b0;
        if (dec_class_ok) begin
            case (dec_op)
                OP_ADD, OP_SUB, OP_MUL, OP_DIV, OP_MOD: begin
                    nxt_res = arith_res;
                    nxt_wr  = 1'b1;
                end
                OP_OR, OP_AND, OP_XOR, OP_MOV, OP_LSH, OP_RSH, OP_NEG, OP_ARSH: begin
                    nxt_res = ls_res;
                    nxt_wr  = 1'b1;
                end
                OP_END: begin
                    nxt_res = bs_res;
                    nxt_wr  = (dec_swap != SW_BAD);
                end
                default: begin
                    nxt_res = '0;
                    nxt_wr  = 1'b0;
                end
            endcase
        end
    end

    // Output register with one-cycle valid.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid  <= 1'b0;
            out_wr_en  <= 1'b0;
            out_result <= '0;
        end else begin
            out_valid <= in_valid;
            out_wr_en <= in_valid && nxt_wr;
            if (in_valid) out_result <= nxt_res;
        end
    end

    AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !out_wr_en)); // R1
    AST_DIV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dec_class_ok && dec_op == OP_DIV && dec_opb == '0) |=> (out_wr_en && out_result == '0)); // R4
    AST_MOD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dec_class_ok && dec_op == OP_MOD && dec_opb == '0) |=> (out_wr_en && out_result == $past(dst_val))); // R5
    AST_BAD_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !dec_class_ok) |=> (!out_wr_en && out_result == '0)); // R10
    AST_NARROW_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dec_class_ok && !dec_wide && dec_op != OP_MOD && dec_op != OP_END) |=> (out_result[W-1:H] == '0)); // R11
endmodule

// File: tb/pfvm_alu_test.sv
// Self-checking bench: a behavioural reference model compared on every clock.
module pfvm_alu_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  opcode = 8'h0;
    logic [63:0] dst_val = 64'h0;
    logic [63:0] src_val = 64'h0;
    logic [31:0] imm = 32'h0;
    logic        out_valid;
    logic        out_wr_en;
    logic [63:0] out_result;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    bit prev_valid = 0;
    string cur_tag = "";

    bit [63:0] q_res[$];
    bit        q_wr[$];
    bit        q_nar[$];
    string     q_tag[$];

    always #2.5 clk = ~clk;

    pfvm_alu uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .dst_val(dst_val), .src_val(src_val), .imm(imm),
        .out_valid(out_valid), .out_wr_en(out_wr_en), .out_result(out_result)
    );

    function automatic string tag_of(input bit [7:0] o);
        bit ok = (o[2:0] == 3'h7) || (o[2:0] == 3'h4);
        if (!ok) return "R10";
        case (o[7:4])
            4'h0, 4'h1, 4'h2: return "R3";
            4'h3: return "R4";
            4'h9: return "R5";
            4'h4, 4'h5, 4'hA, 4'hB: return "R6";
            4'h6, 4'h7, 4'hC: return "R7";
            4'h8: return "R8";
            4'hD: return "R9";
            default: return "R10";
        endcase
    endfunction

    function automatic void model(input bit [7:0] o, input bit [63:0] d, input bit [63:0] s,
                                  input bit [31:0] im, output bit wr, output bit [63:0] r,
                                  output bit nar);
        bit w64;
        bit ok;
        bit [63:0] a;
        bit [63:0] b;
        int sh;
        int nb;
        longint sa;
        int sa32;
        w64 = (o[2:0] == 3'h7);
        ok  = w64 || (o[2:0] == 3'h4);
        wr = 1; r = 0; nar = 0; nb = 0;
        if (!ok) begin wr = 0; return; end
        b = o[3] ? s : {{32{im[31]}}, im};
        a = d;
        if (!w64) begin a = {32'h0, d[31:0]}; b = {32'h0, b[31:0]}; end
        sh = w64 ? int'(b[5:0]) : int'(b[4:0]);
        case (o[7:4])
            4'h0: r = a + b;
            4'h1: r = a - b;
            4'h2: r = a * b;
            4'h3: r = (b == 0) ? 64'h0 : a / b;
            4'h4: r = a | b;
            4'h5: r = a & b;
            4'h6: r = a << sh;
            4'h7: r = a >> sh;
            4'h8: r = 64'h0 - a;
            4'h9: begin
                if (b == 0) begin r = d; return; end
                r = a % b;
            end
            4'hA: r = a ^ b;
            4'hB: r = b;
            4'hC: begin
                if (w64) begin sa = longint'(a); r = 64'(sa >>> sh); end
                else begin sa32 = int'(a[31:0]); r = {32'h0, 32'(sa32 >>> sh)}; end
            end
            4'hD: begin
                if (im == 32'd16) nb = 2;
                else if (im == 32'd32) nb = 4;
                else if (im == 32'd64) nb = 8;
                else begin wr = 0; r = 0; return; end
                for (int k = 0; k < nb; k++) begin
                    if (o[3]) r[8*k +: 8] = d[8*(nb-1-k) +: 8];
                    else      r[8*k +: 8] = d[8*k +: 8];
                end
                return;
            end
            default: begin wr = 0; r = 0; return; end
        endcase
        if (!w64) begin r[63:32] = 32'h0; nar = 1; end
    endfunction

    // Compare the previous cycle's expectation, then capture this cycle's input.
    always @(negedge clk) begin
        bit ewr;
        bit enar;
        bit [63:0] eres;
        string et;
        if (!rst_n) begin
            prev_valid = 0;
        end else begin
            checks++;
            if (out_valid !== prev_valid || (!prev_valid && out_wr_en !== 1'b0)) begin
                fails++;
                $display("FAIL R1 valid/wr: actual %b/%b expected %b/0", out_valid, out_wr_en, prev_valid);
            end
            if (prev_valid && q_res.size() > 0) begin
                eres = q_res.pop_front(); ewr = q_wr.pop_front();
                enar = q_nar.pop_front(); et = q_tag.pop_front();
                checks++;
                if (out_wr_en !== ewr || out_result !== eres) begin
                    fails++;
                    $display("FAIL %s: actual wr=%b res=%h expected wr=%b res=%h", et, out_wr_en, out_result, ewr, eres);
                end
                if (enar) begin
                    checks++;
                    if (out_result[63:32] !== 32'h0) begin
                        fails++;
                        $display("FAIL R11 upper half: actual %h expected 00000000", out_result[63:32]);
                    end
                end
            end
            prev_valid = in_valid;
            if (in_valid) begin
                model(opcode, dst_val, src_val, imm, ewr, eres, enar);
                q_res.push_back(eres); q_wr.push_back(ewr); q_nar.push_back(enar);
                q_tag.push_back(cur_tag != "" ? cur_tag : tag_of(opcode));
            end
        end
    end

    function automatic bit [7:0] opc(input int op, input bit reg_src, input bit w64);
        return {op[3:0], reg_src, w64 ? 3'h7 : 3'h4};
    endfunction

    task automatic send(input bit [7:0] o, input bit [63:0] d, input bit [63:0] s,
                        input bit [31:0] im, input string t);
        @(posedge clk); #1;
        in_valid = 1'b1; opcode = o; dst_val = d; src_val = s; imm = im; cur_tag = t;
    endtask

    task automatic idle();
        @(posedge clk); #1;
        in_valid = 1'b0; cur_tag = "";
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_wr_en !== 1'b0 || out_result !== 64'h0) begin
            fails++;
            $display("FAIL R1 reset: actual %b %b %h expected 0 0 0", out_valid, out_wr_en, out_result);
        end
        @(posedge clk); #1 rst_n = 1'b1;
        idle();
        // R2 source select: same op, immediate versus register, both classes
        send(opc(0, 0, 1), 64'h10, 64'h1000, 32'h5, "R2");
        send(opc(0, 1, 1), 64'h10, 64'h1000, 32'h5, "R2");
        send(opc(11, 0, 0), 64'h0, 64'hFFFF_FFFF_1234_5678, 32'h8000_0000, "R2");
        send(opc(11, 0, 1), 64'h0, 64'h0, 32'h8000_0000, "R2");
        // R3 sign-extended immediate, wraparound, products
        send(opc(0, 0, 1), 64'h100, 64'h0, 32'hFFFF_FFFF, "R3");
        send(opc(0, 0, 0), 64'h1_0000_0100, 64'h0, 32'hFFFF_FFFF, "R3");
        send(opc(1, 1, 1), 64'h0, 64'h1, 32'h0, "R3");
        send(opc(2, 1, 0), 64'h1_FFFF_FFFF, 64'h2, 32'h0, "R3");
        send(opc(2, 1, 1), 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 32'h0, "R3");
        // R4 division including zero divisor
        send(opc(3, 1, 1), 64'd100, 64'd7, 32'h0, "R4");
        send(opc(3, 1, 1), 64'd100, 64'd0, 32'h0, "R4");
        send(opc(3, 1, 0), 64'hABCD_0000_0000_0064, 64'h5_0000_0000, 32'h0, "R4");
        send(opc(3, 0, 1), 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 32'hFFFF_FFFF, "R4");
        // R5 modulo including zero divisor in both classes
        send(opc(9, 1, 1), 64'd100, 64'd7, 32'h0, "R5");
        send(opc(9, 1, 1), 64'hDEAD_BEEF_0000_0042, 64'd0, 32'h0, "R5");
        send(opc(9, 1, 0), 64'hDEAD_BEEF_0000_0042, 64'h7_0000_0000, 32'h0, "R5");
        // R6 bitwise
        send(opc(4, 1, 1), 64'hF0F0, 64'h0F0F, 32'h0, "R6");
        send(opc(5, 0, 1), 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 32'h8000_00FF, "R6");
        send(opc(10, 1, 0), 64'hFFFF_0000_AAAA_5555, 64'hFFFF_FFFF_FFFF_FFFF, 32'h0, "R6");
        // R7 shift masking and sign fill
        send(opc(6, 0, 1), 64'h1, 64'h0, 32'd63, "R7");
        send(opc(6, 0, 1), 64'h1, 64'h0, 32'd64, "R7");
        send(opc(6, 0, 0), 64'h1, 64'h0, 32'd33, "R7");
        send(opc(7, 1, 1), 64'h8000_0000_0000_0000, 64'd63, 32'h0, "R7");
        send(opc(12, 1, 1), 64'h8000_0000_0000_0000, 64'd63, 32'h0, "R7");
        send(opc(12, 0, 0), 64'h0000_0000_8000_0000, 64'h0, 32'd4, "R7");
        send(opc(7, 0, 0), 64'hFFFF_FFFF_8000_0000, 64'h0, 32'd4, "R7");
        // R8 negation corners
        send(opc(8, 0, 1), 64'h0, 64'h0, 32'h0, "R8");
        send(opc(8, 0, 1), 64'h8000_0000_0000_0000, 64'h0, 32'h0, "R8");
        send(opc(8, 0, 0), 64'h1234_0000_0000_0001, 64'h0, 32'h0, "R8");
        // R9 byte order, all widths and both endiannesses
        for (int w = 0; w < 3; w++) begin
            send(opc(13, 0, 0), 64'h0102_0304_0506_0708, 64'h0, 32'd16 << w, "R9");
            send(opc(13, 1, 0), 64'h0102_0304_0506_0708, 64'h0, 32'd16 << w, "R9");
        end
        send(opc(13, 1, 1), 64'h1122_3344_5566_7788, 64'h0, 32'd64, "R9");
        // R10 illegal encodings
        send(8'hD4, 64'h1, 64'h0, 32'd24, "R10");
        send(8'hE7, 64'h1, 64'h2, 32'h3, "R10");
        send(8'hF4, 64'h1, 64'h2, 32'h3, "R10");
        send(8'h05, 64'h1, 64'h2, 32'h3, "R10");
        send(8'h0F, 64'h1, 64'h2, 32'h3, "R10");
        idle();
        // Mixed sequence with gaps
        for (int i = 0; i < 4000; i++) begin
            int pick = $urandom_range(0, 99);
            if (pick < 20) idle();
            else begin
                bit [7:0] o;
                bit [63:0] d, s;
                bit [31:0] im;
                o  = opc($urandom_range(0, 13), 1'($urandom), 1'($urandom));
                if (pick < 26) o = 8'($urandom);
                d  = {$urandom, $urandom};
                s  = ($urandom_range(0, 9) == 0) ? 64'h0 : {$urandom, $urandom};
                if ($urandom_range(0, 3) == 0) s = 64'($urandom_range(0, 70));
                im = ($urandom_range(0, 9) == 0) ? 32'h0 : $urandom;
                if ($urandom_range(0, 3) == 0) im = 32'($urandom_range(0, 70));
                if (o[7:4] == 4'hD && $urandom_range(0, 3) != 0) im = 32'd16 << $urandom_range(0, 2);
                send(o, d, s, im, "");
            end
        end
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end
endmodule